// File: doc/BRIEF.md
# Control Endpoint Stall and Setup-End Tracker

This block follows endpoint zero of a USB device function controller through every control transfer. A packet engine hands it one event per transaction: the token kind, the data toggle seen on the data packet, the byte count, the direction and length carried by a SETUP, and a flag for any protocol violation it found. The block picks the handshake for that transaction (ACK, NAK or STALL). It keeps the control-transfer phase, the expected data toggle and the bytes still owed in the data stage.

It also holds three status flags that firmware reads and clears. The first says a packet is waiting for the CPU. The second says the hardware forced a stall. The third says a transfer was cut short. A forced stall covers a single transaction and drops the transfer. A SETUP whose data toggle is wrong still gets ACK, and the stall lands on the token that follows it. If a hardware set and a CPU clear hit the same flag in the same cycle, the set wins.

Top module: `ctl_ep_guard`

## Requirements
- R1: While and after reset, `csr` reads 0x00, `hs_vld` is 0 and `phase` is IDLE (phase codes: 0 IDLE, 1 data-in, 2 data-out, 3 status).
- R2: A SETUP (token kind 2'b01) with toggle bit 0 is answered one cycle later with `hs_vld`=1 and `hs_code`=ACK (ACK 2'b01, NAK 2'b10, STALL 2'b11). This holds even while a stall is pending. The SETUP sets packet-ready (`csr` bit 0) and moves `phase` to status when the length is 0, otherwise to data-in or data-out according to `tok_dir_in`.
- R3: A SETUP with toggle bit 1 is answered with ACK and does not set packet-ready. The next IN (2'b10) or OUT (2'b11) token is answered with STALL and sets forced-stall (`csr` bit 2).
- R4: An IN or OUT token with `tok_err`=1 is answered with STALL, sets forced-stall and returns `phase` to IDLE.
- R5: A forced stall lasts one transaction. Afterwards `phase` is IDLE. The next SETUP starts a new transfer that runs normally, with no further stall.
- R6: An IN or OUT token while `phase` is IDLE is answered with STALL and sets forced-stall.
- R7: A CPU write with bit 2 at 0 clears forced-stall. A write with bit 2 at 1 leaves it unchanged.
- R8: Setup-end (`csr` bit 4) is set when a new SETUP or an early status token arrives while the data stage still owes bytes. It stays 0 when the data stage completes.
- R9: A CPU write with bit 7 at 1 clears setup-end, and one with bit 6 at 1 clears packet-ready. A 0 in those bits leaves each flag unchanged.
- R10: When a hardware set and a CPU clear of the same flag fall in the same cycle, the flag ends up set.
- R11: In the data-out stage, an OUT is NAKed while packet-ready is set. An OUT whose toggle differs from the expected one is ACKed but does not set packet-ready. An accepted packet flips the expected toggle, which starts at 1 after a SETUP. In the data-in stage, an IN with `tx_ready`=0 is NAKed, and an accepted IN reports its toggle on `hs_tgl`.
- R12: When the owed byte count reaches zero, `phase` becomes status. Any IN or OUT token there is ACKed with `hs_tgl`=1 and returns `phase` to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_vld | input | 1 | One-cycle transaction event |
| tok_kind | input | 2 | 01 SETUP, 10 IN, 11 OUT, 00 ignored |
| tok_len | input | LEN_W | Requested length (SETUP) or packet byte count |
| tok_dir_in | input | 1 | SETUP data stage is device-to-host |
| tok_tgl | input | 1 | Data toggle of the received data packet |
| tok_err | input | 1 | Protocol violation flagged by the packet engine |
| tx_ready | input | 1 | CPU has loaded an IN packet |
| cpu_we | input | 1 | CPU status-register write strobe |
| cpu_wd | input | 8 | CPU write data |
| hs_vld | output | 1 | Handshake decision valid |
| hs_code | output | 2 | ACK, NAK or STALL |
| hs_tgl | output | 1 | Toggle of the data sent for an accepted IN |
| csr | output | 8 | Status: bit 0 packet-ready, bit 2 forced-stall, bit 4 setup-end |
| phase | output | 2 | Control-transfer phase |

## Verification
The hardest case to reach from the ports is a flag that gets a hardware set and a CPU clear in the same cycle, with nothing else masking the result. To get there, the bench drives the token event and the register write on the same clock edge. It does this once for packet-ready, with a SETUP, and once for forced-stall, with a flagged protocol error. The delayed stall after a bad-toggle SETUP is the other hard case. It is reached with a SETUP, then an IN, then a fresh SETUP and its status token, and the bench checks that the stall fires on the IN only.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIN  = 2'd1,
    PH_DOUT = 2'd2,
    PH_STAT = 2'd3
  } ph_e;

  localparam logic [1:0] K_SETUP = 2'b01;
  localparam logic [1:0] K_IN    = 2'b10;
  localparam logic [1:0] K_OUT   = 2'b11;

  localparam logic [1:0] HS_ACK   = 2'b01;
  localparam logic [1:0] HS_NAK   = 2'b10;
  localparam logic [1:0] HS_STALL = 2'b11;

  localparam int NFLAG  = 3;
  localparam int F_ORDY = 0;
  localparam int F_FSTL = 1;
  localparam int F_SEND = 2;

  localparam int CSR_ORDY = 0;
  localparam int CSR_FSTL = 2;
  localparam int CSR_SEND = 4;
  localparam int WR_CLR_ORDY = 6;
  localparam int WR_CLR_SEND = 7;
endpackage

// File: rtl/ctl_ep_flag_bank.sv
module ctl_ep_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> q[i]); // R10
  end
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_vld,
  input  logic [1:0]       tok_kind,
  input  logic [LEN_W-1:0] tok_len,
  input  logic             tok_dir_in,
  input  logic             tok_tgl,
  input  logic             tok_err,
  input  logic             tx_ready,
  input  logic             ordy_q,
  output logic             hs_vld,
  output logic [1:0]       hs_code,
  output logic             hs_tgl,
  output ph_e              phase_q,
  output logic             set_ordy,
  output logic             set_fstl,
  output logic             set_send
);
  logic [LEN_W-1:0] rem_q, rem_n, rem_sub;
  logic             tgl_q, tgl_n, pend_q, pend_n;
  ph_e              phase_n;
  logic             hv_n, ht_n;
  logic [1:0]       hc_n;
  logic             is_in, is_data;

  assign is_in   = (tok_kind == K_IN);
  assign is_data = (tok_kind == K_IN) || (tok_kind == K_OUT);
  assign rem_sub = (rem_q > tok_len) ? (rem_q - tok_len) : '0;

  always_comb begin
    phase_n  = phase_q;
    rem_n    = rem_q;
    tgl_n    = tgl_q;
    pend_n   = pend_q;
    hv_n     = 1'b0;
    hc_n     = HS_ACK;
    ht_n     = 1'b0;
    set_ordy = 1'b0;
    set_fstl = 1'b0;
    set_send = 1'b0;
    if (tok_vld && tok_kind == K_SETUP) begin
      hv_n  = 1'b1;
      tgl_n = 1'b1;
      if ((phase_q == PH_DIN || phase_q == PH_DOUT) && rem_q != '0)
        set_send = 1'b1;
      if (tok_tgl) begin
        pend_n  = 1'b1;
        phase_n = PH_IDLE;
        rem_n   = '0;
      end else begin
        pend_n   = 1'b0;
        set_ordy = 1'b1;
        rem_n    = tok_len;
        if (tok_len == '0) phase_n = PH_STAT;
        else if (tok_dir_in) phase_n = PH_DIN;
        else phase_n = PH_DOUT;
      end
    end else if (tok_vld && is_data) begin
      hv_n = 1'b1;
      if (pend_q || tok_err || phase_q == PH_IDLE) begin
        hc_n     = HS_STALL;
        set_fstl = 1'b1;
        pend_n   = 1'b0;
        phase_n  = PH_IDLE;
        rem_n    = '0;
      end else begin
        unique case (phase_q)
          PH_DIN: begin
            if (is_in) begin
              if (!tx_ready) hc_n = HS_NAK;
              else begin
                ht_n  = tgl_q;
                tgl_n = ~tgl_q;
                rem_n = rem_sub;
                if (rem_sub == '0) phase_n = PH_STAT;
              end
            end else begin
              ht_n     = 1'b1;
              set_send = (rem_q != '0);
              phase_n  = PH_IDLE;
            end
          end
          PH_DOUT: begin
            if (!is_in) begin
              if (ordy_q) hc_n = HS_NAK;
              else if (tok_tgl == tgl_q) begin
                set_ordy = 1'b1;
                tgl_n    = ~tgl_q;
                rem_n    = rem_sub;
                if (rem_sub == '0) phase_n = PH_STAT;
              end
            end else begin
              ht_n     = 1'b1;
              set_send = (rem_q != '0);
              phase_n  = PH_IDLE;
            end
          end
          default: begin
            ht_n    = 1'b1;
            phase_n = PH_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      rem_q   <= '0;
      tgl_q   <= 1'b0;
      pend_q  <= 1'b0;
      hs_vld  <= 1'b0;
      hs_code <= HS_ACK;
      hs_tgl  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      rem_q   <= rem_n;
      tgl_q   <= tgl_n;
      pend_q  <= pend_n;
      hs_vld  <= hv_n;
      hs_code <= hc_n;
      hs_tgl  <= ht_n;
    end
  end

  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (rst)
    tok_vld && tok_kind == K_SETUP |=> hs_vld && hs_code == HS_ACK); // R2
  AST_PEND_STALL: assert property (@(posedge clk) disable iff (rst)
    pend_q && tok_vld && is_data |=> hs_code == HS_STALL); // R3
  AST_HS_AFTER_TOK: assert property (@(posedge clk) disable iff (rst)
    !tok_vld |=> !hs_vld); // R2
endmodule

// File: rtl/ctl_ep_guard.sv
module ctl_ep_guard
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_vld,
  input  logic [1:0]       tok_kind,
  input  logic [LEN_W-1:0] tok_len,
  input  logic             tok_dir_in,
  input  logic             tok_tgl,
  input  logic             tok_err,
  input  logic             tx_ready,
  input  logic             cpu_we,
  input  logic [7:0]       cpu_wd,
  output logic             hs_vld,
  output logic [1:0]       hs_code,
  output logic             hs_tgl,
  output logic [7:0]       csr,
  output logic [1:0]       phase
);
  logic [NFLAG-1:0] fset, fclr, fq;
  ph_e              ph;
  logic             unused_wd;

  assign unused_wd = ^{cpu_wd[5:3], cpu_wd[1:0]};

  always_comb begin
    fclr         = '0;
    fclr[F_ORDY] = cpu_we && cpu_wd[WR_CLR_ORDY];
    fclr[F_FSTL] = cpu_we && !cpu_wd[CSR_FSTL];
    fclr[F_SEND] = cpu_we && cpu_wd[WR_CLR_SEND];
  end

  ctl_ep_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .tok_vld(tok_vld), .tok_kind(tok_kind),
    .tok_len(tok_len), .tok_dir_in(tok_dir_in), .tok_tgl(tok_tgl),
    .tok_err(tok_err), .tx_ready(tx_ready), .ordy_q(fq[F_ORDY]),
    .hs_vld(hs_vld), .hs_code(hs_code), .hs_tgl(hs_tgl), .phase_q(ph),
    .set_ordy(fset[F_ORDY]), .set_fstl(fset[F_FSTL]), .set_send(fset[F_SEND])
  );

  ctl_ep_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(fset), .clr_i(fclr), .q(fq)
  );

  always_comb begin
    csr           = '0;
    csr[CSR_ORDY] = fq[F_ORDY];
    csr[CSR_FSTL] = fq[F_FSTL];
    csr[CSR_SEND] = fq[F_SEND];
  end
  assign phase = ph;

  AST_STALL_FLAG: assert property (@(posedge clk) disable iff (rst)
    hs_vld && hs_code == HS_STALL |-> csr[CSR_FSTL]); // R4
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    hs_vld && hs_code == HS_STALL |-> phase == 2'd0); // R5
endmodule

// File: tb/tb_ctl_ep_guard.sv
module tb_ctl_ep_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] SU = 2'b01, TI = 2'b10, TO = 2'b11;
  localparam logic [1:0] ACK = 2'b01, NAK = 2'b10, STL = 2'b11;

  logic clk = 0, rst = 1;
  logic tok_vld = 0, tok_dir_in = 0, tok_tgl = 0, tok_err = 0, tx_ready = 0;
  logic [1:0] tok_kind = 0;
  logic [15:0] tok_len = 0;
  logic cpu_we = 0;
  logic [7:0] cpu_wd = 0;
  logic hs_vld, hs_tgl;
  logic [1:0] hs_code, phase;
  logic [7:0] csr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_ep_guard dut (
    .clk(clk), .rst(rst), .tok_vld(tok_vld), .tok_kind(tok_kind),
    .tok_len(tok_len), .tok_dir_in(tok_dir_in), .tok_tgl(tok_tgl),
    .tok_err(tok_err), .tx_ready(tx_ready), .cpu_we(cpu_we), .cpu_wd(cpu_wd),
    .hs_vld(hs_vld), .hs_code(hs_code), .hs_tgl(hs_tgl), .csr(csr), .phase(phase)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", rq, act, exp);
    end
  endtask

  task automatic cyc(input logic tv, input logic [1:0] k, input logic [15:0] ln,
                     input logic d, input logic t, input logic e, input logic r,
                     input logic we, input logic [7:0] wd);
    @(negedge clk);
    tok_vld = tv; tok_kind = k; tok_len = ln; tok_dir_in = d;
    tok_tgl = t; tok_err = e; tx_ready = r; cpu_we = we; cpu_wd = wd;
    @(negedge clk);
    tok_vld = 0; cpu_we = 0;
  endtask

  task automatic tok(input logic [1:0] k, input logic [15:0] ln, input logic d,
                     input logic t, input logic e, input logic r);
    cyc(1, k, ln, d, t, e, r, 0, 8'h00);
  endtask

  task automatic wr(input logic [7:0] wd);
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 1, wd);
  endtask

  task automatic hs(input string rq, input logic [1:0] c);
    chk(rq, {7'd0, hs_vld}, 8'h01);
    chk(rq, {6'd0, hs_code}, {6'd0, c});
  endtask

  task automatic t_reset;
    chk("R1 csr", csr, 8'h00);
    chk("R1 hs_vld", {7'd0, hs_vld}, 8'h00);
    chk("R1 phase", {6'd0, phase}, 8'h00);
  endtask

  task automatic t_ctl_write;
    tok(SU, 8, 0, 0, 0, 0);
    hs("R2 setup ack", ACK); chk("R2 ordy", csr, 8'h01); chk("R2 phase", {6'd0, phase}, 8'h02);
    tok(TO, 4, 0, 1, 0, 0); hs("R11 nak busy", NAK);
    wr(8'h44); chk("R9 clr ordy", csr, 8'h00);
    tok(TO, 4, 0, 0, 0, 0); hs("R11 dup ack", ACK); chk("R11 dup no ordy", csr, 8'h00);
    tok(TO, 4, 0, 1, 0, 0); hs("R11 accept", ACK); chk("R11 ordy", csr, 8'h01);
    chk("R12 still data", {6'd0, phase}, 8'h02);
    wr(8'h44);
    tok(TO, 4, 0, 0, 0, 0); hs("R11 flip", ACK); chk("R12 status", {6'd0, phase}, 8'h03);
    tok(TI, 0, 0, 0, 0, 0); hs("R12 status ack", ACK);
    chk("R12 tgl", {7'd0, hs_tgl}, 8'h01); chk("R12 idle", {6'd0, phase}, 8'h00);
    chk("R8 no send", csr, 8'h01);
    wr(8'h44);
  endtask

  task automatic t_ctl_read;
    tok(SU, 10, 1, 0, 0, 0); chk("R2 phase in", {6'd0, phase}, 8'h01);
    wr(8'h44);
    tok(TI, 8, 0, 0, 0, 0); hs("R11 in nak", NAK);
    tok(TI, 8, 0, 0, 0, 1); hs("R11 in ack", ACK); chk("R11 tgl1", {7'd0, hs_tgl}, 8'h01);
    chk("R11 still in", {6'd0, phase}, 8'h01);
    tok(TI, 8, 0, 0, 0, 1); chk("R11 tgl0", {7'd0, hs_tgl}, 8'h00);
    chk("R12 status", {6'd0, phase}, 8'h03);
    tok(TO, 0, 0, 1, 0, 0); hs("R12 ack", ACK); chk("R12 idle", {6'd0, phase}, 8'h00);
    chk("R8 complete", csr, 8'h00);
  endtask

  task automatic t_bad_setup;
    tok(SU, 8, 1, 1, 0, 1); hs("R3 ack first", ACK); chk("R3 no ordy", csr, 8'h00);
    tok(TI, 8, 0, 0, 0, 1); hs("R3 stall", STL); chk("R3 fstl", csr, 8'h04);
    chk("R5 idle", {6'd0, phase}, 8'h00);
    tok(SU, 0, 0, 0, 0, 0); hs("R5 new setup", ACK); chk("R5 csr", csr, 8'h05);
    chk("R5 status", {6'd0, phase}, 8'h03);
    tok(TI, 0, 0, 0, 0, 1); hs("R5 no repeat", ACK);
  endtask

  task automatic t_fstl_clear;
    wr(8'hFF); chk("R7 keep fstl", csr, 8'h04);
    wr(8'h00); chk("R7 clear fstl", csr, 8'h00);
  endtask

  task automatic t_err;
    tok(SU, 4, 1, 0, 0, 0);
    tok(TI, 4, 0, 0, 1, 1); hs("R4 stall", STL); chk("R4 csr", csr, 8'h05);
    chk("R4 idle", {6'd0, phase}, 8'h00);
    wr(8'h40); chk("R7 R9 clear", csr, 8'h00);
    tok(TO, 0, 0, 0, 0, 0); hs("R6 idle stall", STL); chk("R6 fstl", csr, 8'h04);
    wr(8'h00);
  endtask

  task automatic t_setup_end;
    tok(SU, 16, 0, 0, 0, 0); wr(8'h44);
    tok(TO, 8, 0, 1, 0, 0); wr(8'h44);
    tok(SU, 0, 0, 0, 0, 0); chk("R8 new setup", csr, 8'h11);
    wr(8'h80); chk("R9 clr send", csr, 8'h01);
    wr(8'h00); chk("R9 zero ignored", csr, 8'h01);
    wr(8'h40); chk("R9 clr ordy", csr, 8'h00);
    tok(TI, 0, 0, 0, 0, 0);
    tok(SU, 8, 1, 0, 0, 0); wr(8'h44);
    tok(TI, 4, 0, 0, 0, 1);
    tok(TO, 0, 0, 1, 0, 0); hs("R8 early ack", ACK); chk("R8 early", csr, 8'h10);
    chk("R8 idle", {6'd0, phase}, 8'h00);
    wr(8'h80); chk("R9 clr", csr, 8'h00);
  endtask

  task automatic t_same_cycle;
    cyc(1, SU, 8, 1, 0, 0, 0, 1, 8'h40); chk("R10 ordy wins", csr, 8'h01);
    cyc(1, TI, 8, 0, 0, 1, 1, 1, 8'h00); chk("R10 fstl wins", csr, 8'h05);
    wr(8'h40); chk("R10 cleanup", csr, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_reset();
    t_ctl_write();
    t_ctl_read();
    t_bad_setup();
    t_fstl_clear();
    t_err();
    t_setup_end();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule